// File: doc/BRIEF.md
# Subarray Delay-and-Sum Beamformer

This block steers a ring-shaped microphone array towards one of a fixed set of horizontal directions. It takes one filtered PCM sample per microphone on every strobe of a shared valid. It stores each microphone's recent history in a small circular buffer and picks from that buffer the sample that lies a direction-dependent number of sample periods in the past. All picked samples are added into one beamformed sample. The microphones form four concentric rings of 4, 8, 16 and 24 elements. Each ring has its own delay-and-sum unit, with a buffer depth sized to that ring's own largest delay. The four ring sums are then added, and a ring that is switched off adds zero.

The direction index and the ring enable mask are captured together at the start of each sensing window of `WIN_LEN` valid samples. A power estimator placed downstream therefore sees one steady direction per window. Changing direction never empties the buffers, so the filter front end runs without pause. Only a ring that is switched off and on again has to refill its buffer before output resumes.

Top module: `bf_beamformer`

## Requirements
- R1: After reset `valid_o` is 0 and `beam_o` is 0 until the first accepted sample has passed through the pipeline.
- R2: With direction index o, microphone k (0-based, local to its ring) of a ring with N elements contributes the sample received (k + o) mod N valid strobes before the current one. Ring r occupies the `samples_i` slots starting at the sum of the sizes of rings 0..r-1, in ring order 4, 8, 16, 24, and each slot is `SAMPLE_W` bits, two's complement.
- R3: `beam_o` is `SAMPLE_W + ceil(log2(52))` bits wide and holds the exact sum, even when every microphone carries full-scale positive or negative values.
- R4: A ring whose enable bit (bit r of `sub_enable_i`) is 0 adds zero to the sum and does not write its buffer. After it is enabled again, it must refill before it counts as ready.
- R5: `valid_o` is asserted only when at least one ring is enabled and every enabled ring has received at least N-1 consecutive enabled samples before the current one. This means the output waits for the largest delay of the enabled rings.
- R6: `orient_i` and `sub_enable_i` are captured on the first valid strobe of each window of `WIN_LEN` valid strobes, counted from reset, and that strobe already uses the new values. Changes inside a window take effect at the next window start.
- R7: A change of direction does not empty the buffers: the first sample of a new direction's window produces a valid output if the rings were already filled.
- R8: A sample accepted on clock edge E produces `valid_o` and `beam_o` that appear after edge E+2, for exactly one cycle per accepted sample.
- R9: While `valid_i` is 0, `samples_i` and `orient_i` are ignored. No buffer, window count or output changes, and `valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| samples_i | input | 52*SAMPLE_W | One signed sample per microphone, ring 0 in the lowest slots |
| valid_i | input | 1 | Strobe: all microphone samples are valid this cycle |
| orient_i | input | log2(NUM_ORIENT) | Requested steering direction index |
| sub_enable_i | input | 4 | Per-ring enable mask, bit r for ring r |
| beam_o | output | SAMPLE_W+6 | Signed beamformed sample |
| valid_o | output | 1 | Strobe for `beam_o` |

## Verification
A wrong write pointer or read address in a ring buffer corrupts `beam_o` on the very first valid output that uses that ring. The bench compares every output against a sum it rebuilds from its own sample history, so such an error surfaces within one strobe. A fill counter that counts wrongly, or that fails to clear on disable, shows up as `valid_o` rising one or more strobes too early or too late after reset or after a ring is re-enabled. The mask sweep hits that boundary for every combination of rings. A window counter off by one moves the direction switch by a strobe, which changes the summed delays on the first sample of each window.

// File: rtl/bf_pkg.sv
package bf_pkg;
  localparam int unsigned NUM_SUB = 4;
  localparam int unsigned SUB_N [NUM_SUB] = '{4, 8, 16, 24};

  // first microphone slot of ring s
  function automatic int unsigned sub_base(int unsigned s);
    int unsigned b;
    b = 0;
    for (int unsigned i = 0; i < NUM_SUB; i++) begin
      if (i < s) b += SUB_N[i];
    end
    return b;
  endfunction

  localparam int unsigned NUM_MIC = sub_base(NUM_SUB);
endpackage

// File: rtl/bf_cfg_latch.sv
module bf_cfg_latch #(
  parameter int unsigned WIN_LEN = 256,
  parameter int unsigned OIW     = 6,
  parameter int unsigned NUM_SUB = 4,
  localparam int unsigned CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [OIW-1:0]     orient_i,
  input  logic [NUM_SUB-1:0] en_i,
  output logic [OIW-1:0]     orient_o,
  output logic [NUM_SUB-1:0] en_o,
  output logic               at_bound_o
);
  logic [CW-1:0]      cnt_q;
  logic [OIW-1:0]     orient_q;
  logic [NUM_SUB-1:0] en_q;

  assign at_bound_o = (cnt_q == '0);
  // window-start strobe already uses the fresh request
  assign orient_o   = at_bound_o ? orient_i : orient_q;
  assign en_o       = at_bound_o ? en_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      orient_q <= '0;
      en_q     <= '0;
    end else if (valid_i) begin
      cnt_q <= (cnt_q == CW'(WIN_LEN - 1)) ? '0 : cnt_q + 1'b1;
      if (at_bound_o) begin
        orient_q <= orient_i;
        en_q     <= en_i;
      end
    end
  end
endmodule

// File: rtl/bf_ring_tap.sv
module bf_ring_tap #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 2,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       wptr_i,
  input  logic [DW-1:0]       dly_i,
  input  logic signed [W-1:0] din_i,
  output logic signed [W-1:0] dout_o
);
  logic signed [W-1:0] mem_q [DEPTH];
  logic [AW-1:0]       rd_addr;

  assign rd_addr = wptr_i - AW'(dly_i);

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wptr_i] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dout_o <= '0;
    else if (we_i) dout_o <= (dly_i == '0) ? din_i : mem_q[rd_addr];
  end
endmodule

// File: rtl/bf_subarray.sv
module bf_subarray #(
  parameter int unsigned W     = 16,
  parameter int unsigned N     = 4,
  parameter int unsigned OIW   = 6,
  parameter int unsigned OUT_W = 22,
  localparam int unsigned DW    = $clog2(N),
  localparam int unsigned DEPTH = 1 << DW,
  localparam int unsigned SW    = W + DW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    en_i,
  input  logic [OIW-1:0]          orient_i,
  input  logic [N*W-1:0]          samples_i,
  output logic signed [OUT_W-1:0] sum_o,
  output logic                    vld_o
);
  logic [DW-1:0]       fill_q;
  logic [DW-1:0]       wptr_q;
  logic                hit_q;
  logic                ready;
  logic                wr;
  logic signed [W-1:0] tap_q [N];
  logic signed [SW-1:0] acc;

  assign ready = (fill_q == DW'(N - 1));
  assign wr    = valid_i & en_i;

  for (genvar m = 0; m < N; m++) begin : g_tap
    logic [DW-1:0] dly;
    // build-time delay table, one entry per orientation
    assign dly = DW'((m + int'(orient_i)) % N);

    bf_ring_tap #(.W(W), .DEPTH(DEPTH), .DW(DW)) u_tap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (wr),
      .wptr_i (wptr_q),
      .dly_i  (dly),
      .din_i  ($signed(samples_i[m*W +: W])),
      .dout_o (tap_q[m])
    );
  end

  always_comb begin
    acc = '0;
    for (int m = 0; m < N; m++) acc = acc + SW'(tap_q[m]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      wptr_q <= '0;
      hit_q  <= 1'b0;
      vld_o  <= 1'b0;
      sum_o  <= '0;
    end else begin
      if (valid_i) begin
        if (!en_i)      fill_q <= '0;
        else if (!ready) fill_q <= fill_q + 1'b1;
      end
      if (wr) wptr_q <= wptr_q + 1'b1;
      hit_q <= wr & ready;
      vld_o <= hit_q;
      sum_o <= hit_q ? OUT_W'(acc) : '0;
    end
  end
endmodule

// File: rtl/bf_combine.sv
module bf_combine #(
  parameter int unsigned NUM_SUB = 4,
  parameter int unsigned OUT_W   = 22
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [NUM_SUB-1:0]       en_i,
  input  logic [NUM_SUB*OUT_W-1:0] sub_sum_i,
  input  logic [NUM_SUB-1:0]       sub_vld_i,
  output logic signed [OUT_W-1:0]  beam_o,
  output logic                     valid_o
);
  logic               act_d1, act_d2;
  logic [NUM_SUB-1:0] en_d1, en_d2;
  logic signed [OUT_W-1:0] total;
  logic               aligned;

  always_comb begin
    total = '0;
    for (int s = 0; s < NUM_SUB; s++) begin
      if (sub_vld_i[s]) total = total + $signed(sub_sum_i[s*OUT_W +: OUT_W]);
    end
  end

  // every enabled ring must present its sum in the same cycle
  assign aligned = act_d2 && (|en_d2) && ((sub_vld_i & en_d2) == en_d2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_d1  <= 1'b0;
      act_d2  <= 1'b0;
      en_d1   <= '0;
      en_d2   <= '0;
      beam_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      act_d1  <= valid_i;
      act_d2  <= act_d1;
      en_d1   <= en_i;
      en_d2   <= en_d1;
      valid_o <= aligned;
      beam_o  <= aligned ? total : '0;
    end
  end
endmodule

// File: rtl/bf_beamformer.sv
module bf_beamformer
  import bf_pkg::*;
#(
  parameter int unsigned SAMPLE_W   = 16,
  parameter int unsigned NUM_ORIENT = 64,
  parameter int unsigned WIN_LEN    = 256,
  localparam int unsigned OIW   = $clog2(NUM_ORIENT),
  localparam int unsigned OUT_W = SAMPLE_W + $clog2(NUM_MIC)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_MIC*SAMPLE_W-1:0] samples_i,
  input  logic                      valid_i,
  input  logic [OIW-1:0]            orient_i,
  input  logic [NUM_SUB-1:0]        sub_enable_i,
  output logic signed [OUT_W-1:0]   beam_o,
  output logic                      valid_o
);
  logic [OIW-1:0]           orient_eff;
  logic [NUM_SUB-1:0]       en_eff;
  logic                     at_bound;
  logic [NUM_SUB*OUT_W-1:0] sub_sum;
  logic [NUM_SUB-1:0]       sub_vld;

  bf_cfg_latch #(.WIN_LEN(WIN_LEN), .OIW(OIW), .NUM_SUB(NUM_SUB)) u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .orient_i   (orient_i),
    .en_i       (sub_enable_i),
    .orient_o   (orient_eff),
    .en_o       (en_eff),
    .at_bound_o (at_bound)
  );

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    localparam int unsigned N = SUB_N[s];
    localparam int unsigned B = sub_base(s);

    bf_subarray #(.W(SAMPLE_W), .N(N), .OIW(OIW), .OUT_W(OUT_W)) u_sub (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (valid_i),
      .en_i      (en_eff[s]),
      .orient_i  (orient_eff),
      .samples_i (samples_i[B*SAMPLE_W +: N*SAMPLE_W]),
      .sum_o     (sub_sum[s*OUT_W +: OUT_W]),
      .vld_o     (sub_vld[s])
    );
  end

  bf_combine #(.NUM_SUB(NUM_SUB), .OUT_W(OUT_W)) u_comb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .en_i      (en_eff),
    .sub_sum_i (sub_sum),
    .sub_vld_i (sub_vld),
    .beam_o    (beam_o),
    .valid_o   (valid_o)
  );
endmodule

// File: rtl/bf_beam_chk.sv
module bf_beam_chk #(
  parameter int unsigned NUM_SUB  = 4,
  parameter int unsigned OIW      = 6,
  parameter int unsigned OUT_W    = 22,
  parameter int unsigned NUM_MIC  = 52,
  parameter int unsigned SAMPLE_W = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] beam_o,
  input logic [NUM_SUB-1:0]      en_eff_i,
  input logic [OIW-1:0]          orient_eff_i,
  input logic                    at_bound_i,
  input logic [NUM_SUB-1:0]      sub_vld_i
);
  localparam longint LIM_HI = longint'(NUM_MIC) * ((longint'(1) << (SAMPLE_W - 1)) - 1);
  localparam longint LIM_LO = -(longint'(NUM_MIC) * (longint'(1) << (SAMPLE_W - 1)));

  logic [NUM_SUB-1:0] en_act;
  assign en_act = en_eff_i & {NUM_SUB{valid_i}};

  a_r8_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i, 3));

  a_r5_need_ring: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(|en_act, 3));

  a_r4_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_vld_i & ~$past(en_act, 2)) == '0);

  a_r6_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_bound_i |-> ($stable(en_eff_i) && $stable(orient_eff_i)));

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (longint'(beam_o) <= LIM_HI && longint'(beam_o) >= LIM_LO));
endmodule

bind bf_beamformer bf_beam_chk #(
  .NUM_SUB  (bf_pkg::NUM_SUB),
  .OIW      (OIW),
  .OUT_W    (OUT_W),
  .NUM_MIC  (bf_pkg::NUM_MIC),
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .valid_o      (valid_o),
  .beam_o       (beam_o),
  .en_eff_i     (en_eff),
  .orient_eff_i (orient_eff),
  .at_bound_i   (at_bound),
  .sub_vld_i    (sub_vld)
);

// File: tb/bf_beamformer_tb.sv
module bf_beamformer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W      = 16;
  localparam int NMIC   = bf_pkg::NUM_MIC;
  localparam int NSUB   = bf_pkg::NUM_SUB;
  localparam int NOR    = 64;
  localparam int WIN    = 8;
  localparam int OW     = W + $clog2(NMIC);
  localparam int MAXS   = 2048;

  logic                  clk;
  logic                  rst_n;
  logic [NMIC*W-1:0]     samples;
  logic                  valid_in;
  logic [5:0]            orient;
  logic [NSUB-1:0]       sub_en;
  logic signed [OW-1:0]  beam;
  logic                  valid_out;

  bf_beamformer #(.SAMPLE_W(W), .NUM_ORIENT(NOR), .WIN_LEN(WIN)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .samples_i    (samples),
    .valid_i      (valid_in),
    .orient_i     (orient),
    .sub_enable_i (sub_en),
    .beam_o       (beam),
    .valid_o      (valid_out)
  );

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  int hist [MAXS][NMIC];
  int n_samp = 0;
  int m_cnt  = 0;
  int m_fill [NSUB];
  int m_or   = 0;
  logic [NSUB-1:0] m_en = '0;

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pix(input int pat, input int n, input int g);
    case (pat)
      1:       return 32767;
      2:       return -32768;
      default: return ((n * 1103 + g * 7919 + n * g * 31) % 4001) - 2000;
    endcase
  endfunction

  // one accepted sample, checked two edges later against the model
  task automatic send(input int ori, input logic [NSUB-1:0] en, input int pat,
                      input string vtag, input string btag);
    int  exp_sum;
    bit  all_rdy;
    bit  exp_v;
    for (int g = 0; g < NMIC; g++) begin
      hist[n_samp][g] = pix(pat, n_samp, g);
      samples[g*W +: W] = 16'(hist[n_samp][g]);
    end
    orient   = 6'(ori);
    sub_en   = en;
    valid_in = 1'b1;
    if (m_cnt == 0) begin
      m_or = ori;
      m_en = en;
    end
    m_cnt = (m_cnt + 1) % WIN;
    all_rdy = 1;
    exp_sum = 0;
    for (int s = 0; s < NSUB; s++) begin
      int nn, bb;
      nn = bf_pkg::SUB_N[s];
      bb = bf_pkg::sub_base(s);
      if (m_en[s]) begin
        if (m_fill[s] < nn - 1) begin
          all_rdy = 0;
          m_fill[s]++;
        end else begin
          for (int k = 0; k < nn; k++) exp_sum += hist[n_samp - ((k + m_or) % nn)][bb + k];
        end
      end else begin
        m_fill[s] = 0;
      end
    end
    exp_v = all_rdy && (m_en != '0);
    n_samp++;
    @(posedge clk);
    @(negedge clk);
    valid_in = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(valid_out == 1'b0, "R8", int'(valid_out), 0);
    @(posedge clk);
    @(negedge clk);
    check(valid_out == exp_v, vtag, int'(valid_out), int'(exp_v));
    if (exp_v) check(int'(beam) == exp_sum, btag, int'(beam), exp_sum);
  endtask

  initial begin
    for (int s = 0; s < NSUB; s++) m_fill[s] = 0;
    rst_n    = 1'b0;
    valid_in = 1'b0;
    samples  = '0;
    orient   = '0;
    sub_en   = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_out == 1'b0, "R1", int'(valid_out), 0);
    check(beam == '0, "R1", int'(beam), 0);

    // R5: first valid only after the widest ring is filled
    for (int i = 0; i < 40; i++) send(5, 4'hF, 0, "R5", "R2");
    // R2/R7: every direction, whole windows, no refill on change
    for (int o = 0; o < NOR; o++)
      for (int i = 0; i < WIN; i++) send(o, 4'hF, 0, "R7", "R2");
    // R6: request changes on every strobe, only window starts count
    for (int i = 0; i < 48; i++) send((i * 11) % NOR, 4'hF, 0, "R6", "R6");
    // R3: full-scale sums
    for (int i = 0; i < 24; i++) send(i % NOR, 4'hF, 1, "R3", "R3");
    for (int i = 0; i < 24; i++) send((i * 3) % NOR, 4'hF, 2, "R3", "R3");
    // R9: idle cycles with junk inputs
    for (int i = 0; i < 6; i++) begin
      samples  = {NMIC{16'h5A5A}} ^ NMIC*W'(i * 977);
      orient   = 6'(i * 7);
      sub_en   = 4'(i);
      valid_in = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check(valid_out == 1'b0, "R9", int'(valid_out), 0);
    end
    for (int i = 0; i < WIN; i++) send(17, 4'hF, 0, "R9", "R9");
    // R4: every ring mask, including refill after re-enable
    for (int mk = 0; mk < 16; mk++)
      for (int i = 0; i < 32; i++) send((mk * 5 + i) % NOR, 4'(mk), 0, "R4", "R4");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule